// File: doc/BRIEF.md
# Slave Bank Translation and Reset Control

This block sits between a set of slave processors and the shared memory crossbar that joins their banks. Each slave issues a 12-bit logical word address. Its upper 4 bits pick one of 16 logical banks and its lower 8 bits are an offset inside the bank. A per-slave table turns the logical bank into a physical bank. Every slave boots at logical address zero, and its logical bank 0 is always steered to its own physical bank. The other 15 logical banks can be pointed at neighbours' banks, for passing messages. The crossbar compares translated physical addresses to settle contention for a bank, and the larger address wins. Writing a table therefore also sets that slave's priority toward each neighbour.

A host processor drives a small register port with an address, write data, a write strobe and registered read data. Through it the host writes and reads back every table entry and a register of per-slave hold-in-reset bits. All slaves come up held in reset. The host may change a slave's table only while that slave is held. A write that breaks this rule, or tries to point logical bank 0 away from the slave's own bank, is dropped and sets a sticky error flag.

Top module: `bmx_bank_map`

## Requirements
- R1: After reset, every slv_reset bit is 1, host_err is 0 and host_rdata is 0. Entry l of slave s's table holds (s + l) mod 16.
- R2: Translation is combinational. Slave s's phys_addr is its table entry for slv_addr[11:8], followed by slv_addr[7:0] unchanged.
- R3: Logical bank 0 of slave s always translates to physical bank s. A write of a value other than s to entry 0 is dropped and sets host_err. A write of s to entry 0 changes nothing and does not set host_err.
- R4: Host map. When host_addr[8] is 0, host_addr[7:4] selects the slave, host_addr[3:0] selects the logical bank, and the entry is carried in data bits [3:0]. host_addr 9'h100 is the reset register, where bit s set to 1 holds slave s in reset.
- R5: A table write to a slave whose reset bit is 1 updates the entry. Translation uses the new entry from the cycle after the write strobe's clock edge.
- R6: A table write to a slave whose reset bit is 0 leaves the table unchanged and sets host_err.
- R7: Once set, host_err stays 1 until the block is reset.
- R8: Read data is registered. After a clock edge, host_rdata shows the addressed register as it was before that edge, zero-extended to 16 bits. Addresses 9'h101 to 9'h1FF read 0, and writes to them have no effect.
- R9: The reset register accepts writes at any time, and slv_reset shows the written value from the cycle after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_addr | input | 9 | Host register address |
| host_wdata | input | 16 | Host write data |
| host_we | input | 1 | Host write strobe |
| host_rdata | output | 16 | Registered host read data |
| host_err | output | 1 | Sticky flag for rejected table writes |
| slv_reset | output | 16 | Hold-in-reset line per slave, 1 = held |
| slv_addr | input | 192 | Logical addresses, 12 bits per slave, slave 0 in the low bits |
| phys_addr | output | 192 | Translated addresses to the crossbar, same packing |

## Verification
Translation is exercised with fresh random addresses on all sixteen slaves in every cycle. The same draws check the rotated default tables, directed rewrites and randomly rewritten tables, so an indexing error between slaves or between entries shows up as a wrong bank. Host traffic is a random mix of table writes, reset-register writes and reads of unmapped addresses, and the random writes to the reset register keep moving slaves in and out of reset. This separates accepted writes from locked ones and keeps the error flag under check. Directed cases cover entry-0 writes with the slave's own value and with a foreign value, a write to a released slave, and a block reset that clears the sticky flag.

// File: rtl/bmx_pkg.sv
package bmx_pkg;
  // Host register target decoded from the host address
  typedef enum logic [1:0] {
    HS_NONE = 2'd0,
    HS_TBL  = 2'd1,
    HS_RST  = 2'd2
  } hsel_e;
endpackage

// File: rtl/bmx_rst_ctl.sv
module bmx_rst_ctl #(
  parameter int SLV_N = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SLV_N-1:0] wr_bits,
  output logic [SLV_N-1:0] hold_o
);
  logic [SLV_N-1:0] hold_q;
  logic [SLV_N-1:0] hold_d;
  logic             hold_ce;

  always_comb begin
    hold_ce = wr_en;
    hold_d  = wr_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '1;
    else if (hold_ce) hold_q <= hold_d;
  end

  assign hold_o = hold_q;

  // R9
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(hold_q));
endmodule

// File: rtl/bmx_map_table.sv
module bmx_map_table #(
  parameter int OWN    = 0,
  parameter int BANK_W = 4,
  parameter int OFS_W  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         hold,
  input  logic                         wr_en,
  input  logic [BANK_W-1:0]            wr_ent,
  input  logic [BANK_W-1:0]            wr_bank,
  input  logic [BANK_W+OFS_W-1:0]      log_addr,
  output logic [BANK_W+OFS_W-1:0]      phys_addr,
  output logic [(1<<BANK_W)*BANK_W-1:0] ent_flat
);
  localparam int ENT_N  = 1 << BANK_W;
  localparam int ADDR_W = BANK_W + OFS_W;
  localparam logic [BANK_W-1:0] OWN_BANK = BANK_W'(OWN);

  logic [BANK_W-1:0] ent_q [ENT_N];
  logic [BANK_W-1:0] ent_d [ENT_N];
  logic              tbl_ce;
  logic [BANK_W-1:0] log_bank;

  // Next state: entry 0 is pinned to the own bank
  always_comb begin
    tbl_ce = wr_en & hold;
    for (int e = 0; e < ENT_N; e++) begin
      if (e == 0)                      ent_d[e] = OWN_BANK;
      else if (wr_ent == BANK_W'(e))   ent_d[e] = wr_bank;
      else                             ent_d[e] = ent_q[e];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENT_N; e++) ent_q[e] <= BANK_W'(OWN + e);
    end else if (tbl_ce) begin
      ent_q <= ent_d;
    end
  end

  // Combinational lookup of the upper address bits
  always_comb begin
    log_bank  = log_addr[ADDR_W-1 -: BANK_W];
    phys_addr = {ent_q[log_bank], log_addr[OFS_W-1:0]};
  end

  for (genvar g = 0; g < ENT_N; g++) begin : g_flat
    assign ent_flat[g*BANK_W +: BANK_W] = ent_q[g];
  end

  // R6
  locked_tbl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> $stable(ent_flat));
endmodule

// File: rtl/bmx_host_if.sv
module bmx_host_if
  import bmx_pkg::*;
#(
  parameter int SLV_N   = 16,
  parameter int BANK_W  = 4,
  parameter int IDX_W   = 4,
  parameter int HADDR_W = 9,
  parameter int HDATA_W = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [HADDR_W-1:0]                  host_addr,
  input  logic [HDATA_W-1:0]                  host_wdata,
  input  logic                                host_we,
  input  logic [SLV_N-1:0]                    hold_bits,
  input  logic [SLV_N*(1<<BANK_W)*BANK_W-1:0] tbl_flat,
  output logic [SLV_N-1:0]                    tbl_we,
  output logic [BANK_W-1:0]                   tbl_ent,
  output logic [BANK_W-1:0]                   tbl_bank,
  output logic                                rst_we,
  output logic [SLV_N-1:0]                    rst_wbits,
  output logic [HDATA_W-1:0]                  host_rdata,
  output logic                                host_err
);
  hsel_e              sel;
  logic [IDX_W-1:0]   slv_idx;
  logic               tgt_held;
  logic               own_ok;
  logic               wr_tbl;
  logic               bad_wr;
  logic               good_tbl;
  logic [HDATA_W-1:0] rd_d;
  logic [HDATA_W-1:0] rd_q;
  logic               err_q;

  // Decode
  always_comb begin
    slv_idx  = host_addr[BANK_W +: IDX_W];
    tbl_ent  = host_addr[BANK_W-1:0];
    tbl_bank = host_wdata[BANK_W-1:0];
    if (!host_addr[HADDR_W-1] && (int'(slv_idx) < SLV_N))
      sel = HS_TBL;
    else if (host_addr[HADDR_W-1] && (host_addr[HADDR_W-2:0] == '0))
      sel = HS_RST;
    else
      sel = HS_NONE;
    tgt_held = hold_bits[slv_idx];
    own_ok   = (tbl_ent != '0) || (tbl_bank == BANK_W'(slv_idx));
    wr_tbl   = host_we && (sel == HS_TBL);
    bad_wr   = wr_tbl && (!tgt_held || !own_ok);
    good_tbl = wr_tbl && tgt_held && own_ok && (tbl_ent != '0);
    for (int i = 0; i < SLV_N; i++)
      tbl_we[i] = good_tbl && (slv_idx == IDX_W'(i));
    rst_we    = host_we && (sel == HS_RST);
    rst_wbits = host_wdata[SLV_N-1:0];
  end

  // Read mux
  always_comb begin
    case (sel)
      HS_TBL:  rd_d = HDATA_W'(tbl_flat[{slv_idx, tbl_ent}*BANK_W +: BANK_W]);
      HS_RST:  rd_d = HDATA_W'(hold_bits);
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (bad_wr) err_q <= 1'b1;
  end

  assign host_rdata = rd_q;
  assign host_err   = err_q;

  // R7
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R6
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && (sel == HS_TBL) && !hold_bits[slv_idx]) |=> err_q);
endmodule

// File: rtl/bmx_bank_map.sv
module bmx_bank_map #(
  parameter int SLV_N   = 16,
  parameter int BANK_W  = 4,
  parameter int OFS_W   = 8,
  parameter int HDATA_W = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [$clog2(SLV_N)+BANK_W:0]     host_addr,
  input  logic [HDATA_W-1:0]                host_wdata,
  input  logic                              host_we,
  output logic [HDATA_W-1:0]                host_rdata,
  output logic                              host_err,
  output logic [SLV_N-1:0]                  slv_reset,
  input  logic [SLV_N*(BANK_W+OFS_W)-1:0]   slv_addr,
  output logic [SLV_N*(BANK_W+OFS_W)-1:0]   phys_addr
);
  localparam int IDX_W   = $clog2(SLV_N);
  localparam int ADDR_W  = BANK_W + OFS_W;
  localparam int ENT_N   = 1 << BANK_W;
  localparam int HADDR_W = IDX_W + BANK_W + 1;
  localparam int TBL_W   = ENT_N * BANK_W;

  // Asynchronous assert, synchronous release
  logic [1:0] sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_int_n = sync_q[1];

  logic [SLV_N-1:0]       tbl_we;
  logic [BANK_W-1:0]      tbl_ent;
  logic [BANK_W-1:0]      tbl_bank;
  logic                   rst_we;
  logic [SLV_N-1:0]       rst_wbits;
  logic [SLV_N-1:0]       hold_bits;
  logic [SLV_N*TBL_W-1:0] tbl_flat;

  bmx_host_if #(
    .SLV_N(SLV_N), .BANK_W(BANK_W), .IDX_W(IDX_W),
    .HADDR_W(HADDR_W), .HDATA_W(HDATA_W)
  ) u_host (
    .clk(clk), .rst_n(rst_int_n),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_we(host_we),
    .hold_bits(hold_bits), .tbl_flat(tbl_flat),
    .tbl_we(tbl_we), .tbl_ent(tbl_ent), .tbl_bank(tbl_bank),
    .rst_we(rst_we), .rst_wbits(rst_wbits),
    .host_rdata(host_rdata), .host_err(host_err)
  );

  bmx_rst_ctl #(.SLV_N(SLV_N)) u_rst (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(rst_we), .wr_bits(rst_wbits), .hold_o(hold_bits)
  );

  assign slv_reset = hold_bits;

  for (genvar s = 0; s < SLV_N; s++) begin : g_slv
    bmx_map_table #(.OWN(s), .BANK_W(BANK_W), .OFS_W(OFS_W)) u_tbl (
      .clk(clk), .rst_n(rst_int_n),
      .hold(hold_bits[s]), .wr_en(tbl_we[s]),
      .wr_ent(tbl_ent), .wr_bank(tbl_bank),
      .log_addr(slv_addr[s*ADDR_W +: ADDR_W]),
      .phys_addr(phys_addr[s*ADDR_W +: ADDR_W]),
      .ent_flat(tbl_flat[s*TBL_W +: TBL_W])
    );

    // R3
    own_bank_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
      (slv_addr[s*ADDR_W+OFS_W +: BANK_W] == '0)
        |-> (phys_addr[s*ADDR_W+OFS_W +: BANK_W] == BANK_W'(s)));
  end
endmodule

// File: tb/tb_bmx_bank_map.sv
module tb_bmx_bank_map;
  logic         clk;
  logic         rst_n;
  logic [8:0]   host_addr;
  logic [15:0]  host_wdata;
  logic         host_we;
  logic [15:0]  host_rdata;
  logic         host_err;
  logic [15:0]  slv_reset;
  logic [191:0] slv_addr;
  logic [191:0] phys_addr;

  bmx_bank_map dut (
    .clk(clk), .rst_n(rst_n),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_we(host_we),
    .host_rdata(host_rdata), .host_err(host_err), .slv_reset(slv_reset),
    .slv_addr(slv_addr), .phys_addr(phys_addr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  logic [3:0]  m_tbl [16][16];
  logic [15:0] m_rst;
  logic        m_err;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < 16; s++)
      for (int l = 0; l < 16; l++) m_tbl[s][l] = 4'((s + l) % 16);
    m_rst = 16'hFFFF;
    m_err = 1'b0;
  endtask

  function automatic logic [15:0] model_read(input logic [8:0] a);
    if (!a[8])          return {12'h000, m_tbl[a[7:4]][a[3:0]]};
    else if (a == 9'h100) return m_rst;
    else                return 16'h0000;
  endfunction

  task automatic model_write(input logic [8:0] a, input logic [15:0] d);
    if (!a[8]) begin
      if (!m_rst[a[7:4]])          m_err = 1'b1;
      else if (a[3:0] == 4'd0) begin
        if (d[3:0] != a[7:4])      m_err = 1'b1;
      end else                     m_tbl[a[7:4]][a[3:0]] = d[3:0];
    end else if (a == 9'h100) begin
      m_rst = d;
    end
  endtask

  function automatic logic [11:0] exp_phys(input int s, input logic [11:0] a);
    return {m_tbl[s][a[11:8]], a[7:0]};
  endfunction

  // One host cycle, entered and left at a falling edge
  task automatic step(input string req, input logic [8:0] a, input logic [15:0] d, input logic we);
    logic [15:0] exp_rd;
    host_addr  = a;
    host_wdata = d;
    host_we    = we;
    exp_rd = model_read(a);
    if (we) model_write(a, d);
    @(negedge clk);
    host_we = 1'b0;
    chk(req, 32'(host_rdata), 32'(exp_rd));
    chk("R9 slv_reset", 32'(slv_reset), 32'(m_rst));
    chk("R7 host_err", 32'(host_err), 32'(m_err));
  endtask

  // R2: translate a random address on every slave
  task automatic xl_check(input string req);
    for (int s = 0; s < 16; s++) slv_addr[s*12 +: 12] = 12'($urandom);
    #1;
    for (int s = 0; s < 16; s++)
      chk(req, 32'(phys_addr[s*12 +: 12]), 32'(exp_phys(s, slv_addr[s*12 +: 12])));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    host_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [8:0]  ra;
    logic [15:0] rd;
    int          pick;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; host_addr = '0; host_wdata = '0; host_we = 1'b0; slv_addr = '0;
    do_reset();

    // R1: reset state
    chk("R1 slv_reset", 32'(slv_reset), 32'h0000FFFF);
    chk("R1 host_err", 32'(host_err), 32'h0);
    chk("R1 host_rdata", 32'(host_rdata), 32'h0);
    xl_check("R1 default map");

    // R4: reset register readback
    step("R4 read rst reg", 9'h100, 16'h0, 1'b0);
    // R5: write slave 3 bank 5 while held, read it back
    step("R5 write", 9'h035, 16'h0009, 1'b1);
    step("R5 readback", 9'h035, 16'h0, 1'b0);
    slv_addr[3*12 +: 12] = 12'h5A7; #1;
    chk("R5 translate", 32'(phys_addr[3*12 +: 12]), 32'h9A7);
    xl_check("R2 after write");

    // R9 then R6: release slave 2, then try to rewrite its table
    step("R9 release", 9'h100, 16'hFFFB, 1'b1);
    step("R6 locked write", 9'h021, 16'h000F, 1'b1);
    step("R6 entry kept", 9'h021, 16'h0, 1'b0);
    chk("R6 flag", 32'(host_err), 32'h1);
    // R3: entry 0 guarded
    step("R3 foreign entry0", 9'h030, 16'h0007, 1'b1);
    step("R3 entry0 kept", 9'h030, 16'h0, 1'b0);
    chk("R3 entry0 value", 32'(host_rdata), 32'h3);
    // R8: unmapped address
    step("R8 unmapped write", 9'h155, 16'h0000, 1'b1);
    step("R8 unmapped read", 9'h155, 16'h0, 1'b0);
    chk("R8 rst untouched", 32'(slv_reset), 32'h0000FFFB);
    // R7: flag survives further traffic
    step("R7 still set", 9'h100, 16'h0, 1'b0);
    xl_check("R3 own banks");

    // Block reset clears flag; entry-0 self write raises no error
    do_reset();
    chk("R1 err cleared", 32'(host_err), 32'h0);
    step("R3 self entry0", 9'h070, 16'h0007, 1'b1);
    chk("R3 no error", 32'(host_err), 32'h0);
    xl_check("R1 map after reset");

    // Random traffic
    for (int i = 0; i < 600; i++) begin
      pick = int'($urandom_range(0, 9));
      if (pick < 6)      ra = {1'b0, 8'($urandom)};
      else if (pick < 8) ra = 9'h100;
      else               ra = 9'h101 + 9'($urandom_range(0, 254));
      rd = 16'($urandom);
      if (ra == 9'h100 && $urandom_range(0, 1) == 0) rd = 16'hFFFF;
      step("R8 random", ra, rd, 1'($urandom));
      xl_check("R2 random");
    end

    finish_run();
  end
endmodule